// File: doc/BRIEF.md
# Shift and Rotate Unit with Extend Flag

This block performs one shift or rotate on the low byte, word or longword of a 32-bit operand and produces the new operand value together with five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C). It covers eight operations. There are arithmetic and logical shifts in both directions, plain rotates in both directions, and rotates that pass through the extend bit, which makes the rotated ring one bit wider than the operand. The caller presents the operand, the size, the operation, the count and the present X flag, and pulses `start`.

The count comes from one of two places. The first is a 3-bit immediate field that encodes 1 to 8. The second is the low six bits of a data register, which gives 0 to 63. The whole shift is done in one pass through a barrel network, with no iteration. The result and the flags are registered. They appear on the cycle after `start`, together with a one-cycle `done` pulse, and they then hold until the next `start`. Bits above the selected size pass through unchanged.

Top module: `shift_rot_unit`

## Requirements
- R1: A `start` high at a rising clock edge loads `result` and all flags from the inputs present at that edge. `done` is high for exactly the following cycle. While `start` is low, `result` and the flags keep their values.
- R2: `size_sel` 00 selects byte (bits 7:0), 01 selects word (bits 15:0), and 10 or 11 selects long (bits 31:0). Result bits above the selected size equal the corresponding operand bits.
- R3: When `cnt_from_reg` is 0, the count is `imm_cnt`, where codes 1..7 mean 1..7 and code 0 means 8. When it is 1, the count is `reg_cnt`, which is the register value modulo 64.
- R4: `op_sel` 000 is ASL and 010 is LSL. Both shift left and fill with zeros. C and X take the last bit shifted out, which is 0 once the count exceeds the operand width.
- R5: `op_sel` 011 is LSR, which fills with zeros, and 001 is ASR, which fills with copies of the sign bit. C and X take the last bit shifted out. For ASR, this is the sign bit once the count reaches the width.
- R6: For ASL, V is 1 exactly when the sign bit of the operand changes value at any step of the shift. V is 0 for every other operation.
- R7: `op_sel` 110 rotates left and 111 rotates right, within the selected width. C is the last bit carried around: the new LSB for a left rotate and the new MSB for a right rotate. X keeps its input value.
- R8: `op_sel` 100 and 101 rotate left and right through a ring of width+1 bits, with X above the MSB. Both C and X take the resulting extend bit, so a count that is a multiple of width+1 leaves the operand unchanged and copies X into C.
- R9: N equals the MSB of the sized result. Z is 1 exactly when the sized result is zero.
- R10: With a count of zero, the result equals the operand, X keeps its input value and V is 0. C is 0, except for the rotates through extend, where C takes X.
- R11: While `rst_n` is low at a clock edge, `done`, `result` and all flags are cleared to 0, whatever the value of `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch one operation at this edge |
| operand | input | 32 | Value to shift or rotate |
| size_sel | input | 2 | 00 byte, 01 word, 1x long |
| op_sel | input | 3 | Operation code (see R4 to R8) |
| cnt_from_reg | input | 1 | 1: count from `reg_cnt`, 0: from `imm_cnt` |
| imm_cnt | input | 3 | Immediate count, 0 encodes 8 |
| reg_cnt | input | 6 | Register count, low six bits |
| x_in | input | 1 | Current extend flag |
| done | output | 1 | One-cycle pulse when the outputs are new |
| result | output | 32 | Shifted operand with upper bits kept |
| x_out | output | 1 | New extend flag |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag |
| v_out | output | 1 | New overflow flag |
| c_out | output | 1 | New carry flag |

## Verification
The hardest cases to reach are at the ends of the count range. Examples are a register count that is an exact multiple of width+1 for the rotates through extend, a count above the width for the shifts, and the ASL overflow that appears only when a sign change happens partway through the shift, not between the first and last value. Directed tasks drive these counts through `reg_cnt` for each size. A sweep then runs every operation and size with counts and operands taken from a shift-register sequence. An independent one-bit-per-step reference model in the bench supplies the expected result and flags for each operation.

// File: rtl/sr_pkg.sv
// Package: shared encodings for the shift/rotate unit.
// Assumes a 32-bit datapath in which byte and word are the quarter and half widths.
package sr_pkg;

    // Operation code; bit 0 is the direction (1 = right), bits 2:1 are the class.
    typedef enum logic [2:0] {
        OP_ASL  = 3'b000,
        OP_ASR  = 3'b001,
        OP_LSL  = 3'b010,
        OP_LSR  = 3'b011,
        OP_RXL  = 3'b100,
        OP_RXR  = 3'b101,
        OP_ROL  = 3'b110,
        OP_ROR  = 3'b111
    } sr_op_e;

    // Operation class taken from op code bits 2:1.
    typedef enum logic [1:0] {
        CL_ARITH = 2'b00,
        CL_LOGIC = 2'b01,
        CL_ROTX  = 2'b10,
        CL_ROT   = 2'b11
    } sr_class_e;

    // Condition flags produced by one operation.
    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } sr_flags_t;

endpackage

// File: rtl/sr_count_sel.sv
// Module: sr_count_sel
// Picks the effective shift count. The immediate field encodes 1..2**IMM_W-1
// directly and zero as 2**IMM_W. The register count arrives already reduced
// to its low CNT_W bits, which makes it modulo 2**CNT_W.
// Assumes that 2**IMM_W fits in CNT_W bits.
module sr_count_sel #(
    parameter int CNT_W = 6,
    parameter int IMM_W = 3
) (
    input  logic             from_reg,
    input  logic [IMM_W-1:0] imm,
    input  logic [CNT_W-1:0] reg_cnt,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] IMM_FULL = CNT_W'(2 ** IMM_W);

    // Select the register count, or decode the immediate field.
    always_comb begin
        if (from_reg) begin
            cnt = reg_cnt;
        end else if (imm == '0) begin
            cnt = IMM_FULL;
        end else begin
            cnt = CNT_W'(imm);
        end
    end
endmodule

// File: rtl/sr_shift_path.sv
// Module: sr_shift_path
// Arithmetic and logical shifts in one pass. The operand is placed in a
// window wide enough for the largest count, so the bit just beyond the kept
// field is the last bit shifted out. Also derives the ASL overflow flag.
// Assumes a_zext holds the operand masked to the size and a_sext the same
// value sign-extended to DATA_W bits.
module sr_shift_path #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6,
    parameter int WID_W  = 6
) (
    input  logic [DATA_W-1:0] a_zext,
    input  logic [DATA_W-1:0] a_sext,
    input  logic [DATA_W-1:0] mask,
    input  logic [WID_W-1:0]  width,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dir_right,
    input  logic              arith,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              v_out
);
    localparam int PAD_W = 2 ** CNT_W;
    localparam int WRK_W = DATA_W + PAD_W;

    logic [WRK_W-1:0]        ext_l;
    logic [WRK_W-1:0]        ext_r;
    logic signed [WRK_W-1:0] sx;
    logic [CNT_W:0]          span;
    logic [DATA_W-1:0]       top_m;
    logic [DATA_W-1:0]       top_bits;
    logic                    v_raw;

    // Left window: the operand sits at the bottom, and bit [width] is the last bit out.
    always_comb begin
        ext_l = WRK_W'(a_zext) << cnt;
    end

    // Right window: the operand sits at the top, and the bit below it is the last bit out.
    always_comb begin
        sx = {a_sext, {PAD_W{1'b0}}};
        if (arith) begin
            ext_r = sx >>> cnt;
        end else begin
            ext_r = {a_zext, {PAD_W{1'b0}}} >> cnt;
        end
    end

    // Choose the direction and trim to the size.
    always_comb begin
        if (dir_right) begin
            res   = DATA_W'(ext_r >> PAD_W) & mask;
            c_out = ext_r[PAD_W-1];
        end else begin
            res   = DATA_W'(ext_l) & mask;
            c_out = ext_l[width];
        end
    end

    // ASL overflow: the top cnt+1 bits are mixed, or any bit is set once cnt >= width.
    always_comb begin
        span     = (CNT_W+1)'(cnt) + (CNT_W+1)'(1);
        top_m    = mask & ~(mask >> span);
        top_bits = a_zext & top_m;
        if ((CNT_W+1)'(cnt) >= (CNT_W+1)'(width)) begin
            v_raw = |a_zext;
        end else begin
            v_raw = (top_bits != '0) && (top_bits != top_m);
        end
        v_out = arith & ~dir_right & v_raw;
    end
endmodule

// File: rtl/sr_rotate_path.sv
// Module: sr_rotate_path
// Plain rotates and rotates through the extend bit. The ring (width bits, or
// width+1 with X on top) is laid twice side by side and a window is cut out,
// so one shifter serves both directions. The count is reduced modulo the
// ring length first.
// Assumes a_zext is masked to the size and width is QTR_W, HALF_W or DATA_W.
module sr_rotate_path #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6,
    parameter int WID_W  = 6
) (
    input  logic [DATA_W-1:0] a_zext,
    input  logic [DATA_W-1:0] mask,
    input  logic [WID_W-1:0]  width,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dir_right,
    input  logic              thru_x,
    input  logic              x_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out
);
    localparam int QTR_W  = DATA_W / 4;
    localparam int HALF_W = DATA_W / 2;
    localparam int ROT_W  = 3 * DATA_W + 4;

    logic [CNT_W-1:0] r;
    logic [WID_W-1:0] len;
    logic [ROT_W-1:0] ring;
    logic [ROT_W-1:0] dbl;
    logic [ROT_W-1:0] tmp;
    logic [ROT_W-1:0] lmask;
    logic [ROT_W-1:0] vres;

    // Ring length and the count reduced modulo that length.
    always_comb begin
        if (thru_x) begin
            len = width + WID_W'(1);
            if (width == WID_W'(QTR_W)) begin
                r = cnt % CNT_W'(QTR_W + 1);
            end else if (width == WID_W'(HALF_W)) begin
                r = cnt % CNT_W'(HALF_W + 1);
            end else begin
                r = cnt % CNT_W'(DATA_W + 1);
            end
        end else begin
            len = width;
            r   = cnt & CNT_W'(width - WID_W'(1));
        end
    end

    // Doubled ring and the rotated window.
    always_comb begin
        ring = ROT_W'(a_zext);
        if (thru_x) begin
            ring = ring | (ROT_W'(x_in) << width);
        end
        dbl = (ring << len) | ring;
        if (dir_right) begin
            tmp = dbl >> r;
        end else begin
            tmp = (dbl << r) >> len;
        end
        lmask = (ROT_W'(1) << len) - ROT_W'(1);
        vres  = tmp & lmask;
    end

    // Split the ring back into the operand and the carry-out.
    always_comb begin
        res = DATA_W'(vres) & mask;
        if (thru_x) begin
            c_out = vres[width];
        end else if (cnt == '0) begin
            c_out = 1'b0;
        end else if (dir_right) begin
            c_out = vres[width - WID_W'(1)];
        end else begin
            c_out = vres[0];
        end
    end
endmodule

// File: rtl/sr_flag_unit.sv
// Module: sr_flag_unit
// Forms X, N, Z, V and C from the sized result and the carry and overflow
// of the active path, following the rules of each operation class.
// Assumes res_sized is already masked to the selected size.
module sr_flag_unit
    import sr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WID_W  = 6
) (
    input  sr_class_e         cls,
    input  logic [DATA_W-1:0] res_sized,
    input  logic [WID_W-1:0]  width,
    input  logic              cnt_zero,
    input  logic              sh_c,
    input  logic              sh_v,
    input  logic              rot_c,
    input  logic              x_in,
    output sr_flags_t         flags
);
    // N and Z come from the result; X, V and C depend on the class.
    always_comb begin
        flags.n = res_sized[width - WID_W'(1)];
        flags.z = (res_sized == '0);
        unique case (cls)
            CL_ARITH, CL_LOGIC: begin
                flags.c = sh_c;
                flags.v = sh_v;
                flags.x = cnt_zero ? x_in : sh_c;
            end
            CL_ROTX: begin
                flags.c = rot_c;
                flags.v = 1'b0;
                flags.x = rot_c;
            end
            default: begin
                flags.c = rot_c;
                flags.v = 1'b0;
                flags.x = x_in;
            end
        endcase
    end
endmodule

// File: rtl/shift_rot_unit.sv
// Module: shift_rot_unit (top)
// One-pass shift/rotate unit for byte, word and long operands, with a
// registered result and registered flags. A start pulse loads the outputs at
// the next edge and raises done for one cycle. The outputs then hold.
// Assumes DATA_W is a multiple of 4; byte and word are its quarter and half.
module shift_rot_unit
    import sr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6,
    parameter int IMM_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    input  logic [1:0]        size_sel,
    input  logic [2:0]        op_sel,
    input  logic              cnt_from_reg,
    input  logic [IMM_W-1:0]  imm_cnt,
    input  logic [CNT_W-1:0]  reg_cnt,
    input  logic              x_in,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              x_out,
    output logic              n_out,
    output logic              z_out,
    output logic              v_out,
    output logic              c_out
);
    localparam int WID_W  = $clog2(DATA_W) + 1;
    localparam int QTR_W  = DATA_W / 4;
    localparam int HALF_W = DATA_W / 2;

    sr_class_e         cls;
    logic              dir_right;
    logic [CNT_W-1:0]  cnt;
    logic [WID_W-1:0]  width;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] a_zext;
    logic [DATA_W-1:0] a_sext;
    logic [DATA_W-1:0] sh_res;
    logic [DATA_W-1:0] rot_res;
    logic [DATA_W-1:0] path_res;
    logic [DATA_W-1:0] merged;
    logic              sh_c;
    logic              sh_v;
    logic              rot_c;
    sr_flags_t         flags_d;
    sr_flags_t         flags_q;
    logic [DATA_W-1:0] result_q;
    logic              done_q;

    // Split the operation code into class and direction.
    always_comb begin
        cls       = sr_class_e'(op_sel[2:1]);
        dir_right = op_sel[0];
    end

    // Width, mask and the zero- and sign-extended forms of the sized operand.
    always_comb begin
        unique case (size_sel)
            2'b00:   width = WID_W'(QTR_W);
            2'b01:   width = WID_W'(HALF_W);
            default: width = WID_W'(DATA_W);
        endcase
        mask   = {DATA_W{1'b1}} >> (WID_W'(DATA_W) - width);
        a_zext = operand & mask;
        a_sext = operand[width - WID_W'(1)] ? (a_zext | ~mask) : a_zext;
    end

    sr_count_sel #(
        .CNT_W (CNT_W),
        .IMM_W (IMM_W)
    ) u_count (
        .from_reg (cnt_from_reg),
        .imm      (imm_cnt),
        .reg_cnt  (reg_cnt),
        .cnt      (cnt)
    );

    sr_shift_path #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .WID_W  (WID_W)
    ) u_shift (
        .a_zext    (a_zext),
        .a_sext    (a_sext),
        .mask      (mask),
        .width     (width),
        .cnt       (cnt),
        .dir_right (dir_right),
        .arith     (cls == CL_ARITH),
        .res       (sh_res),
        .c_out     (sh_c),
        .v_out     (sh_v)
    );

    sr_rotate_path #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .WID_W  (WID_W)
    ) u_rotate (
        .a_zext    (a_zext),
        .mask      (mask),
        .width     (width),
        .cnt       (cnt),
        .dir_right (dir_right),
        .thru_x    (cls == CL_ROTX),
        .x_in      (x_in),
        .res       (rot_res),
        .c_out     (rot_c)
    );

    // Pick the active path and put back the operand bits above the size.
    always_comb begin
        path_res = cls[1] ? rot_res : sh_res;
        merged   = (operand & ~mask) | path_res;
    end

    sr_flag_unit #(
        .DATA_W (DATA_W),
        .WID_W  (WID_W)
    ) u_flags (
        .cls       (cls),
        .res_sized (path_res),
        .width     (width),
        .cnt_zero  (cnt == '0),
        .sh_c      (sh_c),
        .sh_v      (sh_v),
        .rot_c     (rot_c),
        .x_in      (x_in),
        .flags     (flags_d)
    );

    // Output register: load on start, otherwise hold; done marks a new value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= '0;
            flags_q  <= '0;
        end else begin
            done_q <= start;
            if (start) begin
                result_q <= merged;
                flags_q  <= flags_d;
            end
        end
    end

    // Drive the ports from the output register.
    always_comb begin
        done   = done_q;
        result = result_q;
        x_out  = flags_q.x;
        n_out  = flags_q.n;
        z_out  = flags_q.z;
        v_out  = flags_q.v;
        c_out  = flags_q.c;
    end
endmodule

// File: rtl/sr_checker.sv
// Module: sr_checker
// Temporal properties of shift_rot_unit, seen only at its ports.
// Assumes the default 32-bit width for the byte and word field positions.
module sr_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] operand,
    input logic [1:0]        size_sel,
    input logic [2:0]        op_sel,
    input logic              cnt_from_reg,
    input logic [CNT_W-1:0]  reg_cnt,
    input logic              x_in,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic              x_out,
    input logic              n_out,
    input logic              z_out,
    input logic              v_out,
    input logic              c_out
);
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable({x_out, n_out, z_out, v_out, c_out})));

    p_upper_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && size_sel == 2'b00) |=> (result[31:8] == $past(operand[31:8])));

    p_upper_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && size_sel == 2'b01) |=> (result[31:16] == $past(operand[31:16])));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_sel != 3'b000) |=> !v_out);

    p_rot_keeps_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_sel[2:1] == 2'b11) |=> (x_out == $past(x_in)));

    p_rotx_x_eq_c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_sel[2:1] == 2'b10) |=> (x_out == c_out));

    p_byte_nz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && size_sel == 2'b00) |=> ((z_out == (result[7:0] == 8'h00)) && (n_out == result[7])));

    p_zero_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cnt_from_reg && reg_cnt == '0 && !op_sel[2])
        |=> ((result == $past(operand)) && !c_out && !v_out && (x_out == $past(x_in))));

    p_zero_rotx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cnt_from_reg && reg_cnt == '0 && op_sel[2:1] == 2'b10)
        |=> ((result == $past(operand)) && (c_out == $past(x_in))));
endmodule

bind shift_rot_unit sr_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_sr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .operand      (operand),
    .size_sel     (size_sel),
    .op_sel       (op_sel),
    .cnt_from_reg (cnt_from_reg),
    .reg_cnt      (reg_cnt),
    .x_in         (x_in),
    .done         (done),
    .result       (result),
    .x_out        (x_out),
    .n_out        (n_out),
    .z_out        (z_out),
    .v_out        (v_out),
    .c_out        (c_out)
);

// File: tb/shift_rot_unit_bench.sv
// Directed bench for shift_rot_unit. Expected values come from a reference
// model that moves one bit per step.
module shift_rot_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic [1:0]  size_sel = '0;
    logic [2:0]  op_sel = '0;
    logic        cnt_from_reg = 1'b0;
    logic [2:0]  imm_cnt = '0;
    logic [5:0]  reg_cnt = '0;
    logic        x_in = 1'b0;
    logic        done;
    logic [31:0] result;
    logic        x_out, n_out, z_out, v_out, c_out;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    logic [31:0] lfsr = 32'h1D2C_3B4A;

    always #5 clk = ~clk;

    shift_rot_unit u_shift_rot_unit (
        .clk (clk), .rst_n (rst_n), .start (start), .operand (operand),
        .size_sel (size_sel), .op_sel (op_sel), .cnt_from_reg (cnt_from_reg),
        .imm_cnt (imm_cnt), .reg_cnt (reg_cnt), .x_in (x_in), .done (done),
        .result (result), .x_out (x_out), .n_out (n_out), .z_out (z_out),
        .v_out (v_out), .c_out (c_out)
    );

    // Reference: returns {result, x, n, z, v, c}, moving one bit per step.
    function automatic logic [36:0] model(input logic [2:0] op, input logic [1:0] sz,
                                          input int cnt, input logic x, input logic [31:0] a);
        int w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        logic [31:0] m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        logic [31:0] val = a & m;
        logic xx = x, c = 1'b0, v = 1'b0, out, msb, nm;
        for (int i = 0; i < cnt; i++) begin
            msb = val[w-1];
            case (op)
                3'b000, 3'b010: begin
                    out = msb; val = (val << 1) & m; nm = val[w-1];
                    if (op == 3'b000 && nm != msb) v = 1'b1;
                    c = out; xx = out;
                end
                3'b001, 3'b011: begin
                    out = val[0]; val = val >> 1;
                    if (op == 3'b001 && msb) val = val | (32'd1 << (w-1));
                    c = out; xx = out;
                end
                3'b100: begin
                    out = msb; val = ((val << 1) | 32'(xx)) & m; xx = out; c = out;
                end
                3'b101: begin
                    out = val[0]; val = (val >> 1) | (32'(xx) << (w-1)); xx = out; c = out;
                end
                3'b110: begin
                    out = msb; val = ((val << 1) | 32'(out)) & m; c = out;
                end
                default: begin
                    out = val[0]; val = (val >> 1) | (32'(out) << (w-1)); c = out;
                end
            endcase
        end
        if (op[2:1] == 2'b10) c = xx;
        return {(a & ~m) | val, xx, val[w-1], (val == 32'd0), v, c};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drives one operation, then checks the result, the flags, the done pulse and the hold.
    task automatic run_op(input logic [2:0] op, input logic [1:0] sz, input logic from_reg,
                          input logic [2:0] imm, input logic [5:0] rc, input logic x,
                          input logic [31:0] a, input string tag);
        int cnt = from_reg ? int'(rc) : ((imm == 3'd0) ? 8 : int'(imm));
        logic [36:0] exp = model(op, sz, cnt, x, a);
        logic [31:0] held;
        @(negedge clk);
        op_sel = op; size_sel = sz; cnt_from_reg = from_reg; imm_cnt = imm;
        reg_cnt = rc; x_in = x; operand = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b1, "R1", "done pulse", 32'(done), 32'd1);
        check(result === exp[36:5], tag, "result", result, exp[36:5]);
        check({x_out, n_out, z_out, v_out, c_out} === exp[4:0], tag, "flags XNZVC",
              32'({x_out, n_out, z_out, v_out, c_out}), 32'(exp[4:0]));
        held = result;
        operand = ~a; x_in = ~x;
        @(negedge clk);
        check(done === 1'b0, "R1", "done low after pulse", 32'(done), 32'd0);
        check(result === held, "R1", "result held", result, held);
    endtask

    task automatic t_reset;
        @(negedge clk);
        start = 1'b1; operand = 32'hFFFF_FFFF;
        @(negedge clk);
        check(done === 1'b0, "R11", "done in reset", 32'(done), 32'd0);
        check(result === 32'd0, "R11", "result in reset", result, 32'd0);
        check({x_out, n_out, z_out, v_out, c_out} === 5'd0, "R11", "flags in reset",
              32'({x_out, n_out, z_out, v_out, c_out}), 32'd0);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done === 1'b0, "R11", "done after reset", 32'(done), 32'd0);
    endtask

    task automatic t_arith_left;
        run_op(3'b000, 2'b00, 1'b0, 3'd1, 6'd0, 1'b0, 32'h0000_0040, "R6");
        run_op(3'b000, 2'b00, 1'b0, 3'd1, 6'd0, 1'b0, 32'h0000_0021, "R6");
        run_op(3'b000, 2'b01, 1'b1, 3'd0, 6'd3, 1'b1, 32'h0000_0FFF, "R6");
        run_op(3'b000, 2'b01, 1'b1, 3'd0, 6'd5, 1'b0, 32'h0000_F3FF, "R6");
        run_op(3'b000, 2'b10, 1'b1, 3'd0, 6'd33, 1'b1, 32'h0000_0001, "R4");
        run_op(3'b000, 2'b10, 1'b1, 3'd0, 6'd32, 1'b0, 32'h0000_0001, "R4");
    endtask

    task automatic t_arith_right;
        run_op(3'b001, 2'b00, 1'b0, 3'd1, 6'd0, 1'b0, 32'h0000_0081, "R5");
        run_op(3'b001, 2'b01, 1'b1, 3'd0, 6'd20, 1'b0, 32'h0000_8000, "R5");
        run_op(3'b001, 2'b10, 1'b1, 3'd0, 6'd63, 1'b0, 32'h7000_0000, "R5");
        run_op(3'b001, 2'b10, 1'b1, 3'd0, 6'd31, 1'b0, 32'h8000_0000, "R5");
    endtask

    task automatic t_logical;
        run_op(3'b010, 2'b10, 1'b0, 3'd0, 6'd0, 1'b0, 32'h8000_0181, "R4");
        run_op(3'b011, 2'b00, 1'b1, 3'd0, 6'd8, 1'b0, 32'h0000_0080, "R5");
        run_op(3'b011, 2'b01, 1'b1, 3'd0, 6'd17, 1'b1, 32'h0000_FFFF, "R5");
        run_op(3'b010, 2'b00, 1'b1, 3'd0, 6'd9, 1'b1, 32'h0000_00FF, "R4");
    endtask

    task automatic t_count_source;
        for (int k = 0; k < 8; k++) begin
            run_op(3'b010, 2'b10, 1'b0, 3'(k), 6'd0, 1'b0, 32'h0000_0001, "R3");
        end
        run_op(3'b011, 2'b10, 1'b1, 3'd5, 6'd45, 1'b0, 32'hF000_0000, "R3");
    endtask

    task automatic t_rotate;
        run_op(3'b110, 2'b01, 1'b0, 3'd1, 6'd0, 1'b0, 32'h0000_8001, "R7");
        run_op(3'b111, 2'b00, 1'b0, 3'd1, 6'd0, 1'b1, 32'h0000_0001, "R7");
        run_op(3'b110, 2'b10, 1'b1, 3'd0, 6'd40, 1'b1, 32'h1234_5678, "R7");
        run_op(3'b110, 2'b00, 1'b1, 3'd0, 6'd16, 1'b0, 32'h0000_0081, "R7");
        run_op(3'b111, 2'b01, 1'b1, 3'd0, 6'd35, 1'b0, 32'h0000_8421, "R7");
    endtask

    task automatic t_rotate_x;
        run_op(3'b100, 2'b00, 1'b0, 3'd1, 6'd0, 1'b1, 32'h0000_0080, "R8");
        run_op(3'b100, 2'b00, 1'b1, 3'd0, 6'd9, 1'b1, 32'h0000_0055, "R8");
        run_op(3'b101, 2'b10, 1'b1, 3'd0, 6'd33, 1'b0, 32'h0000_0001, "R8");
        run_op(3'b101, 2'b01, 1'b1, 3'd0, 6'd5, 1'b1, 32'h0000_1234, "R8");
        run_op(3'b101, 2'b01, 1'b1, 3'd0, 6'd34, 1'b1, 32'h0000_8001, "R8");
    endtask

    task automatic t_sizes;
        run_op(3'b010, 2'b00, 1'b0, 3'd3, 6'd0, 1'b0, 32'hDEAD_BEEF, "R2");
        run_op(3'b111, 2'b01, 1'b0, 3'd4, 6'd0, 1'b0, 32'hCAFE_1234, "R2");
        run_op(3'b001, 2'b11, 1'b0, 3'd2, 6'd0, 1'b0, 32'h8000_0000, "R2");
    endtask

    task automatic t_flags;
        run_op(3'b010, 2'b00, 1'b0, 3'd1, 6'd0, 1'b0, 32'hFFFF_FF80, "R9");
        run_op(3'b011, 2'b01, 1'b0, 3'd1, 6'd0, 1'b0, 32'h0000_0002, "R9");
        run_op(3'b110, 2'b00, 1'b0, 3'd1, 6'd0, 1'b0, 32'h0000_0040, "R9");
    endtask

    task automatic t_zero_count;
        for (int o = 0; o < 8; o++) begin
            run_op(3'(o), 2'b01, 1'b1, 3'd0, 6'd0, 1'b1, 32'h1357_9BDF, "R10");
            run_op(3'(o), 2'b00, 1'b1, 3'd0, 6'd0, 1'b0, 32'hFFFF_FF80, "R10");
        end
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'b000: return "R6";
            3'b010: return "R4";
            3'b001, 3'b011: return "R5";
            3'b100, 3'b101: return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic t_sweep;
        for (int o = 0; o < 8; o++) begin
            for (int s = 0; s < 3; s++) begin
                for (int t = 0; t < 6; t++) begin
                    lfsr = lfsr ^ (lfsr << 13);
                    lfsr = lfsr ^ (lfsr >> 17);
                    lfsr = lfsr ^ (lfsr << 5);
                    run_op(3'(o), 2'(s), lfsr[0], lfsr[3:1], lfsr[9:4], lfsr[10],
                           lfsr ^ {lfsr[15:0], lfsr[31:16]}, tag_of(3'(o)));
                end
            end
        end
    endtask

    initial begin
        t_reset();
        t_arith_left();
        t_arith_right();
        t_logical();
        t_count_source();
        t_rotate();
        t_rotate_x();
        t_sizes();
        t_flags();
        t_zero_count();
        t_sweep();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule